// File: doc/BRIEF.md
# Sticky Interrupt Status and Alert Controller

This block gathers out-of-limit event flags from a hardware monitor (temperature channels, supply channels, fan tachometers, diode faults and an overtemperature input) into two 8-bit sticky status registers. Status bits are set as soon as an event is seen. They are cleared by a host read only once the event has gone away, so a poll never misses a fault.

Two 8-bit mask registers decide which status bits may drive a single active-low alert output. Masking gates only the alert and never status capture. One summary mask bit covers the whole second status register. A configuration register enables the alert output, which is off after reset. The same register selects whether the fan 4 slot in status B reports a fan 4 failure or an overtemperature event arriving on the shared tach input.

Host access is a plain strobe interface: an address, a write strobe with data, and a read strobe. Read data appears registered one cycle after the read strobe.

Top module: `mon_alert_ctrl`

Register map (8-bit addresses): status A 0x70, status B 0x71, configuration 0x72, mask A 0x74, mask B 0x75.

Status A layout: bits 6, 5 and 4 are remote 2, local and remote 1 temperature. Bits 3..0 are supply channels 3..0. Bit 7 is a summary bit.

Status B layout: bit 7 diode 2 fault, bit 6 diode 1 fault, bit 5 fan 4 failure or shared overtemperature, bits 4..2 fans 3..1, bit 1 overtemperature, bit 0 reserved.

Configuration layout: bit 0 alert enable, bit 1 tach-as-overtemperature select.

## Requirements
- R1: After reset, both status registers, both masks and the configuration register read 0x00, and alert_n is 1.
- R2: An event input that is high at a clock edge sets its status bit at that edge; a read in the following cycle returns the bit as 1.
- R3: A read of a status register while a bit's event input is still high, including an event first arriving in the read cycle itself, leaves that bit set to 1 afterwards.
- R4: A read returns the status value held before the read. It clears only those bits whose event input is low in the read cycle, and status bits never clear without a read.
- R5: Status A bit 7 reads as 1 whenever any status B bit is set; a read of status A does not clear status B.
- R6: With the alert enabled, alert_n goes to 0 on the edge after an unmasked status bit becomes 1. It stays 0 until no unmasked status bit remains, returning to 1 on the edge after the clearing read.
- R7: Mask A bit i (i = 0..6) and mask B bit i (i = 1..7) hold alert_n at 1 for that status bit alone, while the status bit is still set and readable.
- R8: Mask A bit 7 set to 1 holds alert_n at 1 for every status B source.
- R9: With configuration bit 0 at 0, alert_n stays 1 while status bits keep updating.
- R10: With configuration bit 1 at 1, status B bit 5 follows the therm_in input and ignores evt_b[5]; with it at 0, bit 5 follows evt_b[5] and ignores therm_in.
- R11: Mask and configuration registers read back what was written (configuration bits 7..2 read 0). Writes to status addresses have no effect, and unmapped addresses read 0x00.
- R12: Status B bit 0 always reads 0, even with every event input active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_a | input | 7 | Status A events: [6] remote 2, [5] local, [4] remote 1, [3:0] supplies |
| evt_b | input | 7 | Status B events, indexed [7:1]: diodes, fan 4, fans 3..1, overtemperature |
| therm_in | input | 1 | Overtemperature event from the shared tach input |
| reg_addr | input | 8 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rd | input | 1 | Read strobe (clear-on-read for status addresses) |
| reg_rdata | output | 8 | Read data, valid the cycle after reg_rd |
| alert_n | output | 1 | Active-low alert |

## Verification
The hardest situation to reach is an event that first rises in the very cycle a status read is issued. The read must return 0 for that bit while the bit still ends up set. The stimulus reaches it by raising an event input on the same falling edge that starts the read strobe, then issuing two further reads that must return the bit and then zero. A second awkward case is a bit whose event is still active during a read. The bench holds the event across two reads before dropping it, checking that alert_n stays low until the first read after the event ends.

// File: rtl/mon_alert_pkg.sv
// Package: shared constants and types for the alert controller.
// Assumes 8-bit registers and an 8-bit register address space.
package mon_alert_pkg;
    localparam int REG_W     = 8;
    localparam int ADDR_W    = 8;
    localparam int SRC_A_W   = 7;
    localparam int SRC_B_W   = 7;
    localparam int FAN4_SLOT = 4;   // index of status B bit 5 inside the [7:1] bank

    localparam logic [ADDR_W-1:0] ADR_STAT_A = 8'h70;
    localparam logic [ADDR_W-1:0] ADR_STAT_B = 8'h71;
    localparam logic [ADDR_W-1:0] ADR_CFG    = 8'h72;
    localparam logic [ADDR_W-1:0] ADR_MASK_A = 8'h74;
    localparam logic [ADDR_W-1:0] ADR_MASK_B = 8'h75;

    typedef struct packed {
        logic therm_on_tach;
        logic alert_en;
    } cfg_t;

    // Returns 1 when any bit of s is set and not masked by m.
    function automatic logic any_unmasked(input logic [REG_W-1:0] s,
                                          input logic [REG_W-1:0] m);
        return |(s & ~m);
    endfunction
endpackage

// File: rtl/mon_sticky_bank.sv
// Module: bank of sticky status bits.
// Each bit sets when its event is high and clears on a read strobe only
// if its event is low in that cycle (set wins). Assumes synchronous events.
module mon_sticky_bank #(
    parameter int WIDTH = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_i,
    input  logic             rd_clr_i,
    output logic [WIDTH-1:0] q_o
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        // Hold one sticky flag: set dominates, read clears otherwise.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q_o[i] <= 1'b0;
            else
                q_o[i] <= set_i[i] | (q_o[i] & ~rd_clr_i);
        end
    end
endmodule

// File: rtl/mon_reg_file.sv
// Module: host register file with decode, mask and configuration storage.
// Read data is registered; status reads raise a one-cycle clear strobe.
// Assumes at most one access per cycle per strobe; writes to status are dropped.
module mon_reg_file
    import mon_alert_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic [REG_W-1:0]  wdata_i,
    input  logic              rd_i,
    input  logic [REG_W-1:0]  stat_a_i,
    input  logic [REG_W-1:0]  stat_b_i,
    output logic [REG_W-1:0]  rdata_o,
    output logic [REG_W-1:0]  mask_a_o,
    output logic [REG_W-1:0]  mask_b_o,
    output cfg_t              cfg_o,
    output logic              rd_hit_a_o,
    output logic              rd_hit_b_o
);
    logic [REG_W-1:0] rd_mux;

    // Decode status reads into clear strobes.
    always_comb begin
        rd_hit_a_o = rd_i && (addr_i == ADR_STAT_A);
        rd_hit_b_o = rd_i && (addr_i == ADR_STAT_B);
    end

    // Store mask and configuration registers on writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_a_o <= '0;
            mask_b_o <= '0;
            cfg_o    <= '0;
        end else if (wr_i) begin
            case (addr_i)
                ADR_MASK_A: mask_a_o <= wdata_i;
                ADR_MASK_B: mask_b_o <= wdata_i;
                ADR_CFG:    cfg_o    <= cfg_t'(wdata_i[1:0]);
                default:    ;
            endcase
        end
    end

    // Select the value a read returns.
    always_comb begin
        case (addr_i)
            ADR_STAT_A: rd_mux = stat_a_i;
            ADR_STAT_B: rd_mux = stat_b_i;
            ADR_MASK_A: rd_mux = mask_a_o;
            ADR_MASK_B: rd_mux = mask_b_o;
            ADR_CFG:    rd_mux = {{(REG_W-2){1'b0}}, cfg_o};
            default:    rd_mux = '0;
        endcase
    end

    // Register read data on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_o <= '0;
        else if (rd_i)
            rdata_o <= rd_mux;
    end
endmodule

// File: rtl/mon_alert_gate.sv
// Module: combines status and masks into the registered active-low alert.
// Status A bit i is gated by mask A bit i; all of status B is additionally
// gated by mask A bit 7. Output is forced high while the alert is disabled.
module mon_alert_gate
    import mon_alert_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SRC_A_W-1:0]  stat_a_i,
    input  logic [REG_W-1:0]    stat_b_i,
    input  logic [REG_W-1:0]    mask_a_i,
    input  logic [REG_W-1:0]    mask_b_i,
    input  logic                en_i,
    output logic                alert_n_o
);
    logic hit_a, hit_b, fire;

    // Form the combined unmasked-fault request.
    always_comb begin
        hit_a = any_unmasked({1'b0, stat_a_i}, {1'b1, mask_a_i[SRC_A_W-1:0]});
        hit_b = any_unmasked(stat_b_i, mask_b_i) & ~mask_a_i[REG_W-1];
        fire  = en_i & (hit_a | hit_b);
    end

    // Register the alert pin, idle high.
    always_ff @(posedge clk) begin
        if (!rst_n)
            alert_n_o <= 1'b1;
        else
            alert_n_o <= ~fire;
    end
endmodule

// File: rtl/mon_alert_ctrl.sv
// Module: top of the sticky interrupt status and alert controller.
// Routes events into two sticky banks, selects the fan 4 / overtemperature
// source for status B bit 5, builds the summary bit and drives the alert.
module mon_alert_ctrl
    import mon_alert_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SRC_A_W-1:0] evt_a,
    input  logic [7:1]         evt_b,
    input  logic               therm_in,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic               reg_wr,
    input  logic [REG_W-1:0]   reg_wdata,
    input  logic               reg_rd,
    output logic [REG_W-1:0]   reg_rdata,
    output logic               alert_n
);
    logic [SRC_B_W-1:0] evt_b_sel;
    logic [SRC_A_W-1:0] qa;
    logic [SRC_B_W-1:0] qb;
    logic [REG_W-1:0]   stat_a_view, stat_b_view;
    logic [REG_W-1:0]   mask_a_q, mask_b_q;
    cfg_t               cfg_q;
    logic               rd_hit_a, rd_hit_b;

    // Pick the source for the shared fan 4 / overtemperature slot.
    always_comb begin
        evt_b_sel            = evt_b;
        evt_b_sel[FAN4_SLOT] = cfg_q.therm_on_tach ? therm_in : evt_b[5];
    end

    // Build register views: A gets the B summary bit, B has a reserved bit 0.
    always_comb begin
        stat_a_view = {|qb, qa};
        stat_b_view = {qb, 1'b0};
    end

    mon_sticky_bank #(.WIDTH(SRC_A_W)) u_bank_a (
        .clk(clk), .rst_n(rst_n), .set_i(evt_a), .rd_clr_i(rd_hit_a), .q_o(qa)
    );

    mon_sticky_bank #(.WIDTH(SRC_B_W)) u_bank_b (
        .clk(clk), .rst_n(rst_n), .set_i(evt_b_sel), .rd_clr_i(rd_hit_b), .q_o(qb)
    );

    mon_reg_file u_regs (
        .clk(clk), .rst_n(rst_n),
        .addr_i(reg_addr), .wr_i(reg_wr), .wdata_i(reg_wdata), .rd_i(reg_rd),
        .stat_a_i(stat_a_view), .stat_b_i(stat_b_view),
        .rdata_o(reg_rdata), .mask_a_o(mask_a_q), .mask_b_o(mask_b_q),
        .cfg_o(cfg_q), .rd_hit_a_o(rd_hit_a), .rd_hit_b_o(rd_hit_b)
    );

    mon_alert_gate u_gate (
        .clk(clk), .rst_n(rst_n),
        .stat_a_i(qa), .stat_b_i(stat_b_view),
        .mask_a_i(mask_a_q), .mask_b_i(mask_b_q),
        .en_i(cfg_q.alert_en), .alert_n_o(alert_n)
    );
endmodule

// File: rtl/mon_alert_chk.sv
// Module: assertion checker bound to mon_alert_ctrl.
// Observes events, sticky state, read strobes and the alert pin.
module mon_alert_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [6:0] evt_a,
    input logic [7:0] stat_a,
    input logic [7:0] stat_b,
    input logic       rd_hit_a,
    input logic       rd_hit_b,
    input logic       alert_en,
    input logic       alert_n
);
    assert_status_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_a != 7'd0) |=> ((stat_a[6:0] & $past(evt_a)) == $past(evt_a)));

    assert_a_clear_needs_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(stat_a[6:0]) & ~stat_a[6:0]) != 7'd0) |-> $past(rd_hit_a));

    assert_b_clear_needs_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(stat_b) & ~stat_b) != 8'd0) |-> $past(rd_hit_b));

    assert_alert_idle_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !alert_en |=> alert_n);

    assert_alert_has_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !alert_n |-> (($past(stat_a[6:0]) != 7'd0) || ($past(stat_b) != 8'd0)));
endmodule

bind mon_alert_ctrl mon_alert_chk u_chk (
    .clk(clk), .rst_n(rst_n), .evt_a(evt_a),
    .stat_a(stat_a_view), .stat_b(stat_b_view),
    .rd_hit_a(rd_hit_a), .rd_hit_b(rd_hit_b),
    .alert_en(cfg_q.alert_en), .alert_n(alert_n)
);

// File: tb/mon_alert_ctrl_test.sv
`timescale 1ns/1ps
module mon_alert_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] evt_a = '0;
    logic [7:1] evt_b = '0;
    logic       therm_in = 1'b0;
    logic [7:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_rdata;
    logic       alert_n;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;
    logic rd_seen = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    localparam logic [7:0] A_STA = 8'h70, A_STB = 8'h71, A_CFG = 8'h72,
                           A_MKA = 8'h74, A_MKB = 8'h75;

    always #2.5 clk = ~clk;

    mon_alert_ctrl uut (
        .clk(clk), .rst_n(rst_n), .evt_a(evt_a), .evt_b(evt_b), .therm_in(therm_in),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rd(reg_rd),
        .reg_rdata(reg_rdata), .alert_n(alert_n)
    );

    // Monitor: note which cycles carried a read, then compare the result.
    always @(posedge clk) rd_seen <= reg_rd;

    always @(negedge clk) begin
        if (rd_seen) begin
            logic [7:0] e;
            string t;
            n_run++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL scoreboard: read result with no expected item, actual %02h expected none", reg_rdata);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (reg_rdata !== e) begin
                    n_fail++;
                    $display("FAIL %s: actual %02h expected %02h", t, reg_rdata, e);
                end
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    // Driver: issue a read and push its expected value.
    task automatic rd(input logic [7:0] a, input logic [7:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        reg_addr = a; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic chk_alert(input logic e, input string t);
        n_run++;
        if (alert_n !== e) begin
            n_fail++;
            $display("FAIL %s: alert_n actual %0b expected %0b", t, alert_n, e);
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1: reset state
        chk_alert(1'b1, "R1 alert idle");
        rd(A_STA, 8'h00, "R1 status A");
        rd(A_STB, 8'h00, "R1 status B");
        rd(A_MKA, 8'h00, "R1 mask A");
        rd(A_MKB, 8'h00, "R1 mask B");
        rd(A_CFG, 8'h00, "R1 config");

        // R11: config readback; enable alert
        wr(A_CFG, 8'hFD);
        rd(A_CFG, 8'h01, "R11 config readback");

        // R2/R3/R4/R6: held event, reads during and after
        evt_a[5] = 1'b1;
        tick(2);
        chk_alert(1'b0, "R6 alert asserted");
        rd(A_STA, 8'h20, "R2 status set");
        rd(A_STA, 8'h20, "R3 read while active keeps bit");
        evt_a[5] = 1'b0;
        tick(1);
        chk_alert(1'b0, "R6 alert held until read");
        rd(A_STA, 8'h20, "R4 pre-read value");
        tick(1);
        chk_alert(1'b1, "R6 alert released after read");
        rd(A_STA, 8'h00, "R4 cleared");

        // R3: event arrives in the read cycle itself
        evt_a[4] = 1'b1;
        rd(A_STA, 8'h00, "R3 same-cycle read returns old");
        evt_a[4] = 1'b0;
        rd(A_STA, 8'h10, "R3 set wins over read");
        rd(A_STA, 8'h00, "R4 cleared after set-win");

        // R7: mask A bit 6
        wr(A_MKA, 8'h40);
        evt_a[6] = 1'b1; tick(1); evt_a[6] = 1'b0;
        tick(2);
        chk_alert(1'b1, "R7 masked source no alert");
        rd(A_STA, 8'h40, "R7 masked status still set");
        rd(A_STA, 8'h00, "R7 masked status cleared");
        wr(A_MKA, 8'h00);

        // R5: summary bit
        evt_b[3] = 1'b1; tick(1); evt_b[3] = 1'b0;
        tick(1);
        chk_alert(1'b0, "R6 status B alert");
        rd(A_STA, 8'h80, "R5 summary set");
        rd(A_STA, 8'h80, "R5 read A keeps B");
        rd(A_STB, 8'h08, "R5 status B value");
        rd(A_STA, 8'h00, "R5 summary clear");

        // R8: summary mask covers status B
        wr(A_MKA, 8'h80);
        evt_b[7] = 1'b1; tick(1); evt_b[7] = 1'b0;
        tick(2);
        chk_alert(1'b1, "R8 summary mask");
        rd(A_STB, 8'h80, "R8 status B still set");
        wr(A_MKA, 8'h00);

        // R7: mask B bit 1 only
        wr(A_MKB, 8'h02);
        evt_b[1] = 1'b1; tick(1); evt_b[1] = 1'b0;
        tick(2);
        chk_alert(1'b1, "R7 mask B bit1");
        rd(A_STB, 8'h02, "R7 mask B status set");
        evt_b[2] = 1'b1; tick(1); evt_b[2] = 1'b0;
        tick(1);
        chk_alert(1'b0, "R7 unmasked neighbour alerts");
        rd(A_STB, 8'h04, "R7 neighbour status");
        wr(A_MKB, 8'h00);

        // R10: shared slot source select
        wr(A_CFG, 8'h03);
        rd(A_CFG, 8'h03, "R11 config both bits");
        evt_b[5] = 1'b1; tick(1); evt_b[5] = 1'b0;
        rd(A_STB, 8'h00, "R10 fan4 ignored in therm mode");
        therm_in = 1'b1; tick(1); therm_in = 1'b0;
        rd(A_STB, 8'h20, "R10 therm sets bit5");
        wr(A_CFG, 8'h01);
        therm_in = 1'b1; tick(1); therm_in = 1'b0;
        rd(A_STB, 8'h00, "R10 therm ignored in fan mode");
        evt_b[5] = 1'b1; tick(1); evt_b[5] = 1'b0;
        rd(A_STB, 8'h20, "R10 fan4 sets bit5");

        // R9: alert disabled
        wr(A_CFG, 8'h00);
        tick(2);
        chk_alert(1'b1, "R9 disabled idle");
        evt_a[0] = 1'b1; tick(1); evt_a[0] = 1'b0;
        tick(2);
        chk_alert(1'b1, "R9 disabled no alert");
        rd(A_STA, 8'h01, "R9 status still updates");

        // R11: status writes ignored, unmapped reads, mask B readback
        evt_a[2] = 1'b1; tick(1); evt_a[2] = 1'b0;
        wr(A_STA, 8'h00);
        rd(A_STA, 8'h04, "R11 status write ignored");
        wr(A_STB, 8'hFF);
        rd(A_STB, 8'h00, "R11 status B write ignored");
        wr(A_MKB, 8'hA5);
        rd(A_MKB, 8'hA5, "R11 mask B readback");
        rd(8'h10, 8'h00, "R11 unmapped reads zero");
        wr(A_MKB, 8'h00);

        // R12: reserved bit with all sources active
        evt_b = 7'h7F;
        tick(1);
        rd(A_STB, 8'hFE, "R12 reserved bit zero");
        evt_b = '0;
        rd(A_STB, 8'hFE, "R12 pre-read after drop");
        rd(A_STB, 8'h00, "R12 cleared");

        tick(3);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule